// File: doc/BRIEF.md
# Prioritised Channel Service Scheduler

This block decides which of a set of timer channels is handed to a single shared execution engine next. Each channel may want attention for any mix of four causes: a host request, a link raised by another channel, a match event and a capture event. Host and link requests arrive as one-cycle pulses and are held inside the scheduler until that channel is served. Match and capture are level flags owned by the channel hardware. The scheduler only reads and reports them, and the engine clears them at their source.

Software gives every channel a 2-bit priority code that selects high, middle or low, or switches the channel off. Whenever the engine is free, the scheduler picks a level and then the lowest-numbered requesting channel in that level. Levels are visited in a repeating four-slot rotation of high, middle, high, low. This gives high priority half the slots and ensures that middle and low always make progress. Any slot whose level has no requester is skipped.

The grant leaves the block as a held valid strobe with a channel number and a reason vector. The engine's done pulse acts as the ready side of that handshake. A grant stays valid and unchanged until done is seen. It then drops for at least one cycle, and the next grant may be issued on the edge that follows.

Top module: `chan_svc_sched`

## Requirements
- R1: While reset is low, and after its release until the first request, grant_valid_o is low.
- R2: A host or link pulse on a channel is held pending until that channel is granted. The grant clears both held bits, so a single pulse causes exactly one grant.
- R3: Match and capture inputs request service for as long as they are high. The scheduler never clears them, so a channel whose flag stays high is granted again and again.
- R4: A channel whose priority code is 00 is never granted. Its held host or link bits are kept and are served once the code becomes non-zero.
- R5: Priority codes are 11 for high, 10 for middle and 01 for low. Channel i uses bits [2i+1:2i] of prio_i.
- R6: Among requesters of the chosen level, the lowest channel number is granted.
- R7: Only one grant is outstanding at a time. While grant_valid_o is high and eng_done_i is low, the channel and the reason stay unchanged. A done pulse while no grant is outstanding is ignored.
- R8: eng_done_i high during a grant clears grant_valid_o on that edge. The next grant appears no earlier than the following edge.
- R9: Levels are offered in the rotation high, middle, high, low, starting at the first slot after reset. A slot whose level has no requester is skipped. After a grant, the rotation resumes at the slot after the one that was used.
- R10: grant_reason_o bit 0 is host, bit 1 is link, bit 2 is match and bit 3 is capture. Each bit is the value the channel had at the grant edge.
- R11: A host pulse for a channel that lands on the edge where that channel is granted stays pending and causes one further grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_i | input | 2*NUM_CH | Per-channel priority code, 2 bits per channel |
| host_req_i | input | NUM_CH | One-cycle host service pulses |
| link_req_i | input | NUM_CH | One-cycle link pulses from other channels |
| match_evt_i | input | NUM_CH | Match event level flags |
| capture_evt_i | input | NUM_CH | Capture event level flags |
| eng_done_i | input | 1 | Engine finished the granted channel (ready side of grant) |
| grant_valid_o | output | 1 | A grant is outstanding |
| grant_ch_o | output | $clog2(NUM_CH) | Granted channel number |
| grant_reason_o | output | 4 | Causes for the granted channel |

## Verification
The assertions check properties that hold on every cycle. A held grant stays stable until done. Done always releases the grant. A new grant never goes to a disabled channel and always carries a non-empty reason. Each level's pick is the lowest requester. The rotation never idles while a level has work, and a host pulse always sets its held bit. The order of grants across the rotation, the skipping of empty slots, the one-grant-per-pulse behaviour and the retention of requests through a disabled period show up only over many cycles. These are covered by the bench's reference model and its directed sequences.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Priority code carried per channel on prio_i
  typedef enum logic [1:0] {
    PRI_OFF  = 2'b00,
    PRI_LOW  = 2'b01,
    PRI_MID  = 2'b10,
    PRI_HIGH = 2'b11
  } pri_e;

  localparam int NUM_LVL  = 3;   // enabled levels: position 0 low, 1 mid, 2 high
  localparam int NUM_SLOT = 4;   // rotation length
  localparam int RSN_W    = 4;

  typedef struct packed {
    logic capture;
    logic match;
    logic link;
    logic host;
  } reason_t;

  // Rotation slot to level position: slots 0 and 2 high, 1 middle, 3 low
  function automatic logic [1:0] slot_pos(input logic [1:0] slot);
    case (slot)
      2'd1:    slot_pos = 2'd1;
      2'd3:    slot_pos = 2'd0;
      default: slot_pos = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/sched_pending.sv
module sched_pending #(
  parameter int NUM_CH = 16,
  parameter int CHW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] host_set,
  input  logic [NUM_CH-1:0] link_set,
  input  logic              clr_en,
  input  logic [CHW-1:0]    clr_ch,
  output logic [NUM_CH-1:0] host_pend,
  output logic [NUM_CH-1:0] link_pend
);

  logic [NUM_CH-1:0] clr_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign clr_hit[g] = clr_en && (clr_ch == CHW'(g));

    // R2: a pulse always leaves its held bit set on the next cycle
    a_r2_host_latched: assert property (@(posedge clk) disable iff (!rst_n)
      host_set[g] |=> host_pend[g]);
    a_r2_link_latched: assert property (@(posedge clk) disable iff (!rst_n)
      link_set[g] |=> link_pend[g]);
  end

  // A new pulse wins over the clear of the same edge (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_pend <= '0;
      link_pend <= '0;
    end else begin
      host_pend <= host_set | (host_pend & ~clr_hit);
      link_pend <= link_set | (link_pend & ~clr_hit);
    end
  end

endmodule

// File: rtl/sched_level_pick.sv
module sched_level_pick #(
  parameter int NUM_CH = 16,
  parameter int CHW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  output logic              found,
  output logic [CHW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = CHW'(i);
      end
    end
  end

  logic [NUM_CH-1:0] below_mask;
  assign below_mask = (NUM_CH'(1) << idx) - NUM_CH'(1);

  // R6: the chosen channel requests and nothing lower does
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (req[idx] && ((req & below_mask) == '0)));
  a_r6_none_missed: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (req == '0));

endmodule

// File: rtl/sched_rotor.sv
module sched_rotor
  import sched_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] lvl_any,
  input  logic               advance,
  output logic               sel_valid,
  output logic [1:0]         sel_pos
);

  logic [1:0] ptr;
  logic [1:0] sel_slot;
  logic [1:0] cand_slot [NUM_SLOT];
  logic [1:0] cand_pos  [NUM_SLOT];

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_cand
    assign cand_slot[k] = ptr + 2'(k);
    assign cand_pos[k]  = slot_pos(cand_slot[k]);
  end

  // First slot from ptr whose level has a requester; empty slots are skipped
  always_comb begin
    sel_valid = 1'b0;
    sel_pos   = 2'd2;
    sel_slot  = ptr;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (lvl_any[cand_pos[k]]) begin
        sel_valid = 1'b1;
        sel_pos   = cand_pos[k];
        sel_slot  = cand_slot[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= sel_slot + 2'd1;
  end

  // R9: the chosen level has work, and work is never passed over
  a_r9_level_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> lvl_any[sel_pos]);
  a_r9_no_idle_with_work: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_any) |-> sel_valid);

endmodule

// File: rtl/chan_svc_sched.sv
module chan_svc_sched
  import sched_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CHW    = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_CH-1:0]   prio_i,
  input  logic [NUM_CH-1:0]     host_req_i,
  input  logic [NUM_CH-1:0]     link_req_i,
  input  logic [NUM_CH-1:0]     match_evt_i,
  input  logic [NUM_CH-1:0]     capture_evt_i,
  input  logic                  eng_done_i,
  output logic                  grant_valid_o,
  output logic [CHW-1:0]        grant_ch_o,
  output logic [RSN_W-1:0]      grant_reason_o
);

  logic [NUM_CH-1:0]  host_pend;
  logic [NUM_CH-1:0]  link_pend;
  logic [NUM_CH-1:0]  ch_req;
  logic [NUM_LVL-1:0] lvl_any;
  logic [CHW-1:0]     lvl_idx [NUM_LVL];
  logic               sel_valid;
  logic [1:0]         sel_pos;
  logic [CHW-1:0]     pick_ch;
  logic               issue;
  reason_t            pick_rsn;

  assign ch_req = host_pend | link_pend | match_evt_i | capture_evt_i;

  sched_pending #(.NUM_CH(NUM_CH), .CHW(CHW)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_set  (host_req_i),
    .link_set  (link_req_i),
    .clr_en    (issue),
    .clr_ch    (pick_ch),
    .host_pend (host_pend),
    .link_pend (link_pend)
  );

  // One lowest-index finder per enabled level; code 00 matches none (R4)
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_CH-1:0] req_l;
    always_comb begin
      for (int i = 0; i < NUM_CH; i++)
        req_l[i] = ch_req[i] && (prio_i[2*i +: 2] == 2'(l + 1));
    end
    sched_level_pick #(.NUM_CH(NUM_CH), .CHW(CHW)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_l),
      .found (lvl_any[l]),
      .idx   (lvl_idx[l])
    );
  end

  sched_rotor u_rotor (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_any   (lvl_any),
    .advance   (issue),
    .sel_valid (sel_valid),
    .sel_pos   (sel_pos)
  );

  assign pick_ch = lvl_idx[sel_pos];
  assign issue   = !grant_valid_o && sel_valid;

  always_comb begin
    pick_rsn.host    = host_pend[pick_ch];
    pick_rsn.link    = link_pend[pick_ch];
    pick_rsn.match   = match_evt_i[pick_ch];
    pick_rsn.capture = capture_evt_i[pick_ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid_o  <= 1'b0;
      grant_ch_o     <= '0;
      grant_reason_o <= '0;
    end else if (issue) begin
      grant_valid_o  <= 1'b1;
      grant_ch_o     <= pick_ch;
      grant_reason_o <= pick_rsn;
    end else if (grant_valid_o && eng_done_i) begin
      grant_valid_o  <= 1'b0;
    end
  end

  // Previous-cycle priority codes, used only by the checks below
  logic [2*NUM_CH-1:0] prio_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_prev <= '0;
    else        prio_prev <= prio_i;
  end

  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !eng_done_i) |=>
      (grant_valid_o && $stable(grant_ch_o) && $stable(grant_reason_o)));
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && eng_done_i) |=> !grant_valid_o);
  a_r4_never_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |-> (prio_prev[2*grant_ch_o +: 2] != 2'b00));
  a_r10_reason_present: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid_o) |-> (grant_reason_o != '0));

endmodule

// File: tb/chan_svc_sched_bench.sv
module chan_svc_sched_bench;

  localparam int NCH = 16;
  localparam int CW  = $clog2(NCH);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NCH-1:0] prio = '0;
  logic [NCH-1:0]  host_req = '0, link_req = '0, match_evt = '0, cap_evt = '0;
  logic            eng_done = 1'b0;
  logic            grant_valid;
  logic [CW-1:0]   grant_ch;
  logic [3:0]      grant_reason;

  always #10 clk = ~clk;   // 50 MHz

  chan_svc_sched #(.NUM_CH(NCH)) u_chan_svc_sched (
    .clk(clk), .rst_n(rst_n), .prio_i(prio),
    .host_req_i(host_req), .link_req_i(link_req),
    .match_evt_i(match_evt), .capture_evt_i(cap_evt),
    .eng_done_i(eng_done), .grant_valid_o(grant_valid),
    .grant_ch_o(grant_ch), .grant_reason_o(grant_reason)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  bit [NCH-1:0] m_host, m_link;
  bit           m_busy;
  int           m_ch, m_ptr;
  bit [3:0]     m_rsn;

  function automatic int lvl_of_slot(int s);
    return (s == 1) ? 2 : (s == 3) ? 1 : 3;   // code value of the slot's level
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_host = '0; m_link = '0; m_busy = 0; m_ptr = 0; m_ch = 0; m_rsn = '0;
    end else begin
      bit [NCH-1:0] clr;
      clr = '0;
      if (!m_busy) begin
        bit done_search;
        done_search = 0;
        for (int k = 0; k < 4 && !done_search; k++) begin
          int s;
          s = (m_ptr + k) % 4;
          for (int c = 0; c < NCH && !done_search; c++) begin
            if (int'(prio[2*c +: 2]) == lvl_of_slot(s) &&
                (m_host[c] | m_link[c] | match_evt[c] | cap_evt[c])) begin
              done_search = 1;
              m_busy = 1; m_ch = c;
              m_rsn = {cap_evt[c], match_evt[c], m_link[c], m_host[c]};
              m_ptr = (s + 1) % 4;
              clr[c] = 1'b1;
            end
          end
        end
      end else if (eng_done) begin
        m_busy = 0;
      end
      m_host = (m_host & ~clr) | host_req;
      m_link = (m_link & ~clr) | link_req;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- cycle driver ----------------
  int  gq[$];
  int  rq[$];
  bit  prev_gv = 0;
  bit  auto_eng = 1;
  int  eng_lat = 3, wcnt = 0;

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk(grant_valid == m_busy, cur_req, "grant_valid vs model", grant_valid, m_busy);
      if (grant_valid && m_busy) begin
        chk(int'(grant_ch) == m_ch, cur_req, "grant_ch vs model", grant_ch, m_ch);
        chk(grant_reason == m_rsn, cur_req, "reason vs model", grant_reason, m_rsn);
      end
    end
    if (grant_valid && !prev_gv) begin
      gq.push_back(int'(grant_ch));
      rq.push_back(int'(grant_reason));
    end
    prev_gv  = grant_valid;
    host_req = '0;
    link_req = '0;
    if (auto_eng) begin
      if (eng_done) begin
        eng_done = 0; wcnt = 0;
      end else if (grant_valid) begin
        wcnt++;
        if (wcnt >= eng_lat) eng_done = 1;
      end
    end else begin
      eng_done = 0;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_grant(int n);
    for (int i = 0; i < n && !grant_valid; i++) cyc();
  endtask

  task automatic do_reset();
    rst_n = 0; match_evt = '0; cap_evt = '0; prio = '0;
    run(3);
    chk(grant_valid == 0, "R1", "grant_valid in reset", grant_valid, 0);
    rst_n = 1;
    prev_gv = 0;
  endtask

  task automatic run_seq(logic [2*NCH-1:0] p, logic [NCH-1:0] m, int exp[$], string tag);
    do_reset();
    cur_req = tag;
    prio = p; match_evt = m; eng_lat = 1; auto_eng = 1;
    gq.delete();
    for (int i = 0; i < 100 && gq.size() < exp.size(); i++) cyc();
    chk(gq.size() >= exp.size(), tag, "grant count", gq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < gq.size(); i++)
      chk(gq[i] == exp[i], tag, "rotation order", gq[i], exp[i]);
    match_evt = '0;
    run(8);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    // R1: reset state and quiet after release
    do_reset();
    cur_req = "R1";
    run(4);
    chk(grant_valid == 0, "R1", "no grant without request", grant_valid, 0);

    // R2 / R10: single host pulse, host reason bit 0
    cur_req = "R2"; prio = {NCH{2'b11}}; eng_lat = 3;
    host_req[4] = 1'b1;
    wait_grant(10);
    chk(int'(grant_ch) == 4, "R2", "host grant channel", grant_ch, 4);
    chk(grant_reason == 4'b0001, "R10", "host reason bits", grant_reason, 1);
    gq.delete();
    run(15);
    chk(gq.size() == 0, "R2", "one pulse gives one grant", gq.size(), 0);

    // R10: link pulse gives reason bit 1
    cur_req = "R10";
    link_req[11] = 1'b1;
    wait_grant(10);
    chk(int'(grant_ch) == 11, "R10", "link grant channel", grant_ch, 11);
    chk(grant_reason == 4'b0010, "R10", "link reason bits", grant_reason, 2);
    run(8);

    // R10: capture level gives reason bit 3
    cap_evt[2] = 1'b1;
    wait_grant(10);
    chk(grant_reason == 4'b1000, "R10", "capture reason bits", grant_reason, 8);
    cap_evt[2] = 1'b0;
    run(8);

    // R3: a held match flag keeps requesting
    cur_req = "R3"; gq.delete();
    match_evt[7] = 1'b1;
    run(30);
    chk(gq.size() >= 3, "R3", "repeat grants on held match", gq.size(), 3);
    chk(rq.size() > 0 && rq[rq.size()-1] == 4, "R3", "match reason bit 2",
        rq.size() > 0 ? rq[rq.size()-1] : -1, 4);
    match_evt[7] = 1'b0;
    run(8);

    // R4: disabled channel keeps its request until enabled
    cur_req = "R4";
    prio[13:12] = 2'b00;
    host_req[6] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk(grant_valid == 0, "R4", "disabled channel not granted", grant_valid, 0);
    end
    prio[13:12] = 2'b11;
    wait_grant(10);
    chk(grant_valid && int'(grant_ch) == 6, "R4", "granted once enabled", grant_ch, 6);
    chk(grant_reason == 4'b0001, "R4", "held host bit kept", grant_reason, 1);
    run(8);

    // R6: lowest channel first within one level
    cur_req = "R6"; eng_lat = 2; gq.delete();
    host_req[12] = 1'b1; host_req[9] = 1'b1; host_req[15] = 1'b1;
    run(30);
    chk(gq.size() == 3, "R6", "three grants", gq.size(), 3);
    if (gq.size() == 3) begin
      chk(gq[0] == 9,  "R6", "first grant", gq[0], 9);
      chk(gq[1] == 12, "R6", "second grant", gq[1], 12);
      chk(gq[2] == 15, "R6", "third grant", gq[2], 15);
    end

    // R11: pulse on the grant edge stays pending
    cur_req = "R11"; gq.delete();
    host_req[1] = 1'b1;
    cyc();
    host_req[1] = 1'b1;
    run(20);
    chk(gq.size() == 2, "R11", "second grant from late pulse", gq.size(), 2);

    // R7 / R8: manual engine
    cur_req = "R7"; auto_eng = 0;
    host_req[0] = 1'b1;
    wait_grant(10);
    host_req[1] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk(grant_valid && int'(grant_ch) == 0, "R7", "grant held without done", grant_ch, 0);
    end
    cur_req = "R8";
    eng_done = 1'b1;
    cyc();
    chk(grant_valid == 0, "R8", "done drops grant", grant_valid, 0);
    cyc();
    chk(grant_valid && int'(grant_ch) == 1, "R8", "next grant one edge later", grant_ch, 1);
    eng_done = 1'b1;
    cyc();
    cyc();
    cur_req = "R7";
    eng_done = 1'b1;            // done while idle
    cyc();
    host_req[2] = 1'b1;
    cyc();
    cyc();
    chk(grant_valid && int'(grant_ch) == 2, "R7", "grant after idle done", grant_ch, 2);
    cyc();
    chk(grant_valid == 1, "R7", "idle done did not cancel grant", grant_valid, 1);
    eng_done = 1'b1;
    cyc();
    auto_eng = 1;
    run(4);

    // R9 / R5: rotation orders with codes 11/10/01 on ch3/ch5/ch9
    begin
      logic [2*NCH-1:0] p;
      int e[$];
      p = '0; p[7:6] = 2'b11; p[11:10] = 2'b10; p[19:18] = 2'b01;
      e = '{3, 5, 3, 9, 3, 5, 3, 9};
      run_seq(p, 16'h0228, e, "R9");
      p = '0; p[11:10] = 2'b10; p[19:18] = 2'b01;
      e = '{5, 9, 5, 9};
      run_seq(p, 16'h0220, e, "R9");
      p = '0; p[7:6] = 2'b11; p[19:18] = 2'b01;
      e = '{3, 3, 9, 3, 3, 9};
      run_seq(p, 16'h0208, e, "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule